// File: doc/BRIEF.md
# Serial-Load Bank Configuration Interface

This block sits on a CPU write bus and builds four 5-bit configuration registers from a one-bit serial stream. Each CPU write into the upper half of the address space (0x8000 to 0xFFFF) either adds data bit 0 to a shift buffer or, when data bit 7 is set, abandons the sequence in progress. When the fifth bit arrives, the assembled value goes to one of the four registers, chosen by address bits 14:13 of that fifth write. The four registers are presented as parallel buses for downstream bank translation logic. The translation logic is not part of this block.

The same decoder recognises the 0x6000 to 0x7FFF window and drives the chip select, write strobe, offset and write data of an external 8 KiB work RAM. It also returns that RAM's read data on the CPU read bus. Bit 4 of register 3 switches the RAM off. While the RAM is off, writes in the window are dropped and reads in the window return zero. A single-cycle `commit_pulse` marks every register update.

Top module: `serial_bank_loader`

## Requirements
- R1: While `rst_n` is low and just after it, register 0 is 0x02 if `strap_vmirror` is 1 and 0x03 if it is 0. Registers 1 to 3 are zero, the bit count is zero and `commit_pulse` is 0.
- R2: A write to 0x8000-0xFFFF with data bit 7 set clears the bit count and the shift buffer. It ORs register 0 with 0x0C and leaves registers 1 to 3 unchanged.
- R3: Writes to 0x8000-0xFFFF with data bit 7 clear supply data bit 0, least significant bit first. On the fifth such write, the 5-bit value goes to register 0, 1, 2 or 3 according to address bits 14:13 of that write (00, 01, 10 or 11).
- R4: After a commit the count and buffer are zero, so the next five writes form a new value with no bits carried over. A bit-7 write in mid-sequence discards the bits already gathered.
- R5: Registers 1 and 2 hold all five written bits. In register 3, bits 3:0 carry the bank number and bit 4 is the work RAM disable bit.
- R6: A write in 0x6000-0x7FFF while register 3 bit 4 is 0 asserts `wram_cs` and `wram_we` in the same cycle. `wram_addr` is address[12:0] and `wram_wdata` is the CPU data. While bit 4 is 1, `wram_we` and `wram_cs` stay 0.
- R7: `cpu_rdata` equals `wram_rdata` when the address lies in 0x6000-0x7FFF and the RAM is enabled. Otherwise it is 0x00.
- R8: Writes below 0x8000 do not change the registers, the bit count or the shift buffer.
- R9: `commit_pulse` is high for exactly the one cycle after each commit or bit-7 write, and low otherwise.
- R10: With `cpu_we` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_vmirror | input | 1 | Strap selecting the reset value of register 0 |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Single-cycle write strobe |
| wram_rdata | input | 8 | Read data from the work RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| wram_cs | output | 1 | Work RAM select (address in window and RAM enabled) |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM offset |
| wram_wdata | output | 8 | Work RAM write data |
| cfg_ctrl | output | 5 | Register 0, control |
| cfg_chr_a | output | 5 | Register 1, first CHR bank |
| cfg_chr_b | output | 5 | Register 2, second CHR bank |
| cfg_prg | output | 5 | Register 3, PRG bank and RAM disable |
| commit_pulse | output | 1 | One-cycle marker of a register update |

## Verification
The assertions check these properties on every cycle:
- The bit count never reaches five.
- `commit_pulse` follows exactly the cycles after a fifth bit or a bit-7 write.
- Register 0 carries 0x0C after a bit-7 write.
- No register moves without a strobe.
- The RAM write enable and a non-zero read value are never seen with the RAM off or outside the window.

Only the bench's scenarios can show that the bits land in least-significant-first order in the register chosen by the fifth address. They also show that an aborted or interleaved sequence carries no stale bits, and that both strap reset values appear.

// File: rtl/serl_pkg.sv
package serl_pkg;

  localparam int CPU_AW  = 16;
  localparam int CPU_DW  = 8;
  localparam int CFG_W   = 5;
  localparam int CFG_N   = 4;
  localparam int WRAM_AW = 13;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CHRA = 2'd1,
    SEL_CHRB = 2'd2,
    SEL_PRG  = 2'd3
  } cfg_sel_e;

  localparam logic [CFG_W-1:0] CTRL_FORCE = 5'h0C;

  function automatic logic hits_serial_port(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1];
  endfunction

  function automatic logic hits_wram_window(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1:WRAM_AW] == 3'b011;
  endfunction

  function automatic cfg_sel_e target_of(input logic [CPU_AW-1:0] a);
    return cfg_sel_e'(a[CPU_AW-2:WRAM_AW]);
  endfunction

  function automatic logic [CFG_W-1:0] ctrl_reset_value(input logic vmirror);
    return vmirror ? 5'h02 : 5'h03;
  endfunction

endpackage

// File: rtl/serl_shifter.sv
module serl_shifter
  import serl_pkg::*;
#(
  parameter int REG_W = CFG_W,
  localparam int CNT_W = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_hit,
  input  logic             abort_hit,
  input  logic             bit_in,
  output logic             commit_fire,
  output logic [REG_W-1:0] commit_val,
  output logic [CNT_W-1:0] bit_count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [REG_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [REG_W-1:0] place_bit(
    input logic [REG_W-1:0] acc,
    input logic             b,
    input logic [CNT_W-1:0] pos
  );
    return acc | (REG_W'(b) << pos);
  endfunction

  assign commit_fire = shift_hit && (cnt_q == LAST);
  assign commit_val  = place_bit(buf_q, bit_in, cnt_q);
  assign bit_count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (abort_hit || commit_fire) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (shift_hit) begin
      buf_q <= commit_val;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_abort_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (cnt_q == '0) && (buf_q == '0));

endmodule

// File: rtl/serl_regbank.sv
module serl_regbank
  import serl_pkg::*;
#(
  parameter int REG_W = CFG_W,
  parameter int NREG  = CFG_N,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strap_vmirror,
  input  logic                      commit_fire,
  input  logic [SEL_W-1:0]          commit_sel,
  input  logic [REG_W-1:0]          commit_val,
  input  logic                      abort_hit,
  input  logic                      cpu_we,
  output logic [NREG-1:0][REG_W-1:0] regs,
  output logic                      commit_pulse
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam bit IS_CTRL = (g == 0);
    logic hit;
    assign hit = commit_fire && (commit_sel == SEL_W'(g));

    if (IS_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         regs[g] <= ctrl_reset_value(strap_vmirror);
        else if (hit)       regs[g] <= commit_val;
        else if (abort_hit) regs[g] <= regs[g] | CTRL_FORCE;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   regs[g] <= '0;
        else if (hit) regs[g] <= commit_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_pulse <= 1'b0;
    else        commit_pulse <= commit_fire || abort_hit;
  end

  assert_ctrl_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (regs[0][3:2] == 2'b11));

  assert_quiet_without_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> $stable(regs));

endmodule

// File: rtl/serl_wram_dec.sv
module serl_wram_dec
  import serl_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int DW  = CPU_DW,
  parameter int RAW = WRAM_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  input  logic           cpu_we,
  input  logic           ram_off,
  input  logic [DW-1:0]  wram_rdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           wram_cs,
  output logic           wram_we,
  output logic [RAW-1:0] wram_addr,
  output logic [DW-1:0]  wram_wdata
);

  logic in_window;

  assign in_window  = hits_wram_window(cpu_addr);
  assign wram_cs    = in_window && !ram_off;
  assign wram_we    = wram_cs && cpu_we;
  assign wram_addr  = cpu_addr[RAW-1:0];
  assign wram_wdata = cpu_wdata;
  assign cpu_rdata  = wram_cs ? wram_rdata : '0;

  assert_ram_write_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> (cpu_addr[AW-1:RAW] == 3'b011) && !ram_off && cpu_we);

  assert_read_zero_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata != '0) |-> (cpu_addr[AW-1:RAW] == 3'b011) && !ram_off);

endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader
  import serl_pkg::*;
#(
  parameter int AW    = CPU_AW,
  parameter int DW    = CPU_DW,
  parameter int REG_W = CFG_W,
  parameter int RAW   = WRAM_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_vmirror,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_we,
  input  logic [DW-1:0]    wram_rdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             wram_cs,
  output logic             wram_we,
  output logic [RAW-1:0]   wram_addr,
  output logic [DW-1:0]    wram_wdata,
  output logic [REG_W-1:0] cfg_ctrl,
  output logic [REG_W-1:0] cfg_chr_a,
  output logic [REG_W-1:0] cfg_chr_b,
  output logic [REG_W-1:0] cfg_prg,
  output logic             commit_pulse
);

  localparam int NREG  = CFG_N;
  localparam int SEL_W = $clog2(NREG);
  localparam int CNT_W = $clog2(REG_W);

  logic                       serial_write;
  logic                       shift_hit;
  logic                       abort_hit;
  logic                       commit_fire;
  logic [REG_W-1:0]           commit_val;
  logic [CNT_W-1:0]           bit_count;
  logic [SEL_W-1:0]           commit_sel;
  logic [NREG-1:0][REG_W-1:0] regs;
  logic                       ram_off;

  assign serial_write = cpu_we && hits_serial_port(cpu_addr);
  assign abort_hit    = serial_write && cpu_wdata[DW-1];
  assign shift_hit    = serial_write && !cpu_wdata[DW-1];
  assign commit_sel   = SEL_W'(target_of(cpu_addr));

  serl_shifter #(.REG_W(REG_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_hit   (shift_hit),
    .abort_hit   (abort_hit),
    .bit_in      (cpu_wdata[0]),
    .commit_fire (commit_fire),
    .commit_val  (commit_val),
    .bit_count   (bit_count)
  );

  serl_regbank #(.REG_W(REG_W), .NREG(NREG)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_vmirror (strap_vmirror),
    .commit_fire   (commit_fire),
    .commit_sel    (commit_sel),
    .commit_val    (commit_val),
    .abort_hit     (abort_hit),
    .cpu_we        (cpu_we),
    .regs          (regs),
    .commit_pulse  (commit_pulse)
  );

  assign ram_off = regs[SEL_PRG][REG_W-1];

  serl_wram_dec #(.AW(AW), .DW(DW), .RAW(RAW)) u_wram (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_we     (cpu_we),
    .ram_off    (ram_off),
    .wram_rdata (wram_rdata),
    .cpu_rdata  (cpu_rdata),
    .wram_cs    (wram_cs),
    .wram_we    (wram_we),
    .wram_addr  (wram_addr),
    .wram_wdata (wram_wdata)
  );

  assign cfg_ctrl  = regs[SEL_CTRL];
  assign cfg_chr_a = regs[SEL_CHRA];
  assign cfg_chr_b = regs[SEL_CHRB];
  assign cfg_prg   = regs[SEL_PRG];

  assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> $past(serial_write && (cpu_wdata[DW-1] || bit_count == CNT_W'(REG_W-1))));

  assert_cause_has_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_hit || commit_fire) |=> commit_pulse);

  assert_low_writes_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_addr[AW-1]) |=> $stable(regs) && $stable(bit_count));

endmodule

// File: tb/serial_bank_loader_tb.sv
module serial_bank_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_vmirror = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [7:0]  wram_rdata;
  logic [7:0]  cpu_rdata;
  logic        wram_cs, wram_we, commit_pulse;
  logic [12:0] wram_addr;
  logic [7:0]  wram_wdata;
  logic [4:0]  cfg_ctrl, cfg_chr_a, cfg_chr_b, cfg_prg;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Work RAM stand-in: data is a fixed pattern of the offset
  assign wram_rdata = wram_addr[7:0] ^ 8'hA5;

  serial_bank_loader u_dut (
    .clk(clk), .rst_n(rst_n), .strap_vmirror(strap_vmirror),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .wram_rdata(wram_rdata), .cpu_rdata(cpu_rdata), .wram_cs(wram_cs),
    .wram_we(wram_we), .wram_addr(wram_addr), .wram_wdata(wram_wdata),
    .cfg_ctrl(cfg_ctrl), .cfg_chr_a(cfg_chr_a), .cfg_chr_b(cfg_chr_b),
    .cfg_prg(cfg_prg), .commit_pulse(commit_pulse)
  );

  // Behavioural reference model
  int m_reg[4];
  int m_cnt;
  int m_buf;
  bit m_pulse;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg[0] = strap_vmirror ? 2 : 3;
      m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      m_cnt = 0; m_buf = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (cpu_we && cpu_addr >= 16'h8000) begin
        if (cpu_wdata[7]) begin
          m_cnt = 0; m_buf = 0;
          m_reg[0] = m_reg[0] | 12;
          m_pulse = 1;
        end else begin
          m_buf = m_buf + (int'(cpu_wdata[0]) * (1 << m_cnt));
          m_cnt = m_cnt + 1;
          if (m_cnt == 5) begin
            m_reg[(cpu_addr / 16'h2000) % 4] = m_buf;
            m_cnt = 0; m_buf = 0;
            m_pulse = 1;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit win, on;
      int exp_rd;
      win = (cpu_addr >= 16'h6000) && (cpu_addr < 16'h8000);
      on  = win && ((m_reg[3] & 16) == 0);
      exp_rd = on ? int'(cpu_addr[7:0] ^ 8'hA5) : 0;
      check(int'(cfg_ctrl) == m_reg[0], "R3 ctrl", cfg_ctrl, m_reg[0]);
      check(int'(cfg_chr_a) == m_reg[1], "R3 chr_a", cfg_chr_a, m_reg[1]);
      check(int'(cfg_chr_b) == m_reg[2], "R3 chr_b", cfg_chr_b, m_reg[2]);
      check(int'(cfg_prg) == m_reg[3], "R3 prg", cfg_prg, m_reg[3]);
      check(commit_pulse == m_pulse, "R9 pulse", commit_pulse, m_pulse);
      check(wram_we == (on && cpu_we), "R6 we", wram_we, on && cpu_we);
      check(wram_cs == on, "R6 cs", wram_cs, on);
      if (on) check(int'(wram_addr) == int'(cpu_addr[12:0]), "R6 addr", wram_addr, cpu_addr[12:0]);
      check(int'(cpu_rdata) == exp_rd, "R7 rdata", cpu_rdata, exp_rd);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(posedge clk); #2;
    cpu_we = 1'b0;
  endtask

  task automatic load(input int sel, input logic [4:0] v);
    for (int i = 0; i < 5; i++)
      wr(16'h8000 | 16'(sel << 13), {7'b0, v[i]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input bit strap);
    strap_vmirror = strap;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    // R1: reset values with the strap high
    check(cfg_ctrl == 5'h02, "R1 ctrl strap=1", cfg_ctrl, 5'h02);
    check(cfg_chr_a == 0 && cfg_chr_b == 0 && cfg_prg == 0, "R1 others", cfg_prg, 0);
    check(commit_pulse == 0, "R1 pulse", commit_pulse, 0);

    // R3 / R5: fill each register, LSB first, selected by address bits 14:13
    load(1, 5'h16);
    check(cfg_chr_a == 5'h16, "R5 chr_a", cfg_chr_a, 5'h16);
    check(commit_pulse == 1, "R9 pulse after commit", commit_pulse, 1);
    load(2, 5'h1B);
    check(cfg_chr_b == 5'h1B, "R5 chr_b", cfg_chr_b, 5'h1B);
    load(0, 5'h11);
    check(cfg_ctrl == 5'h11, "R3 ctrl load", cfg_ctrl, 5'h11);
    load(3, 5'h0A);
    check(cfg_prg == 5'h0A, "R5 prg bank", cfg_prg, 5'h0A);

    // R3: the fifth write's address chooses the target
    wr(16'h8000, 8'h01); wr(16'hA000, 8'h00); wr(16'hC000, 8'h01);
    wr(16'h8000, 8'h00); wr(16'hA000, 8'h01);
    check(cfg_chr_a == 5'h15, "R3 fifth address selects", cfg_chr_a, 5'h15);

    // R2 / R4: bit-7 abort mid-sequence
    wr(16'hE000, 8'h01); wr(16'hE000, 8'h01); wr(16'hE000, 8'h01);
    wr(16'h9000, 8'h80);
    check(cfg_ctrl == 5'h1D, "R2 ctrl or 0x0C", cfg_ctrl, 5'h1D);
    check(cfg_prg == 5'h0A && cfg_chr_b == 5'h1B, "R2 others kept", cfg_prg, 5'h0A);
    load(3, 5'h04);
    check(cfg_prg == 5'h04, "R4 no stale bits", cfg_prg, 5'h04);

    // R8: writes below 0x8000 inside a sequence do not count
    wr(16'hC000, 8'h01); wr(16'hC000, 8'h01);
    wr(16'h4000, 8'h00); wr(16'h0000, 8'h80); wr(16'h6123, 8'h00);
    check(cfg_ctrl == 5'h1D, "R8 ctrl untouched", cfg_ctrl, 5'h1D);
    wr(16'hC000, 8'h00); wr(16'hC000, 8'h00); wr(16'hC000, 8'h01);
    check(cfg_chr_b == 5'h13, "R8 count untouched", cfg_chr_b, 5'h13);

    // R6 / R7: work RAM window enabled
    @(posedge clk); #2;
    cpu_addr = 16'h7ABC; cpu_wdata = 8'h3C; cpu_we = 1'b1; #1;
    check(wram_we == 1 && wram_addr == 13'h1ABC, "R6 write enabled", wram_addr, 13'h1ABC);
    check(wram_wdata == 8'h3C, "R6 wdata", wram_wdata, 8'h3C);
    @(posedge clk); #2; cpu_we = 1'b0; #1;
    check(cpu_rdata == (8'hBC ^ 8'hA5), "R7 read enabled", cpu_rdata, 8'hBC ^ 8'hA5);

    // R5 / R6 / R7: register 3 bit 4 switches the RAM off
    load(3, 5'h17);
    @(posedge clk); #2;
    cpu_addr = 16'h6010; cpu_wdata = 8'h55; cpu_we = 1'b1; #1;
    check(wram_we == 0 && wram_cs == 0, "R6 write blocked", wram_we, 0);
    @(posedge clk); #2; cpu_we = 1'b0; #1;
    check(cpu_rdata == 0, "R7 read zero when off", cpu_rdata, 0);
    check(cfg_prg == 5'h17, "R5 disable bit", cfg_prg, 5'h17);

    // R10: idle cycles change nothing
    idle(6);
    check(cfg_prg == 5'h17 && cfg_ctrl == 5'h1D, "R10 idle", cfg_prg, 5'h17);
    check(commit_pulse == 0, "R9 pulse low when idle", commit_pulse, 0);

    // R1: reset with the strap low
    do_reset(1'b0);
    check(cfg_ctrl == 5'h03, "R1 ctrl strap=0", cfg_ctrl, 5'h03);
    check(cfg_prg == 0, "R1 prg cleared", cfg_prg, 0);
    load(1, 5'h09);
    check(cfg_chr_a == 5'h09, "R4 count zero after reset", cfg_chr_a, 5'h09);

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule